// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block creates the START and STOP conditions on the two-wire bus for an I2C master. Software asks for a condition with one write to a control word. The write carries three bits: a master bit, a transmit bit and a bus-busy bit. The block then drives the open-drain style clock line (SCL) and data line (SDA) through a setup interval and a hold interval. Both intervals are counted in system clock cycles. Each speed mode has its own interval lengths, and START and STOP also use different lengths.

When a START finishes, the block raises a one-cycle pulse. This pulse clears the bit counter and starts one byte of clocking in the byte engine. That byte engine lives outside this block. A busy flag tells software that the bus is held. The flag sets when the START data edge is issued and clears when the STOP sequence ends. Requests that are not valid are dropped, and so are writes that arrive while a sequence is running. In both cases the bus lines do not change.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, scl_o=1, sda_o=1, bus_busy_o=0 and byte_start_o=0.
- R2: A START is taken from a write with master=1, transmit=1 and busy bit=1, but only while enable_i=1 and bus_busy_o=0. Any other combination of bits starts no START.
- R3: In standard mode (fast_mode_i=0), a START releases both lines on the write edge. SDA falls 20 cycles after the write edge and SCL falls 20 cycles after that.
- R4: In high-speed mode (fast_mode_i=1), the START setup and hold are 10 cycles each.
- R5: bus_busy_o becomes 1 in the same cycle as the START SDA fall.
- R6: byte_start_o is a single-cycle pulse in the same cycle as the START SCL fall.
- R7: A STOP is taken from a write with master=1, transmit=1 and busy bit=0, while enable_i=1. On the write edge SCL is released high and SDA is held low.
- R8: In standard mode, SDA rises 20 cycles after the STOP write edge, and bus_busy_o clears 18 cycles after that.
- R9: In high-speed mode, the STOP setup is 12 cycles and the hold is 10 cycles.
- R10: A write made while enable_i=0, or a START write made while bus_busy_o=1, leaves scl_o, sda_o and bus_busy_o unchanged.
- R11: A write that arrives while a sequence is running is dropped, and the running sequence keeps its timing.
- R12: SDA changes only while SCL is high, and was high in the previous cycle too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Bus interface enable |
| fast_mode_i | input | 1 | 1 selects high-speed timing, 0 selects standard timing |
| wr_stb_i | input | 1 | Control word write strobe |
| wr_master_i | input | 1 | Master bit of the write |
| wr_transmit_i | input | 1 | Transmit bit of the write |
| wr_busy_i | input | 1 | Bus-busy bit of the write |
| scl_o | output | 1 | Clock line, 1 = released |
| sda_o | output | 1 | Data line, 1 = released |
| bus_busy_o | output | 1 | Bus-held flag |
| byte_start_o | output | 1 | Pulse that clears the bit counter and starts byte clocking |

## Verification
Every result is measured in cycles from the clock edge that samples the write.

- On that edge, the release of the lines is visible on the following falling edge. That point is offset 0.
- The START SDA fall and the busy flag are due at the setup offset.
- The SCL fall and the byte pulse are due at the setup plus hold offset. The pulse must be gone one cycle later.
- For a STOP, the SDA rise is due at the setup offset and the busy flag clears at the setup plus hold offset.

The bench drives on falling edges and counts falling edges after the write. It records the first offset at which each line changes and compares that offset with the exact expected count. A change that comes one cycle early or one cycle late is reported. Writes that must be dropped are followed by a fixed wait, after which all three outputs are compared with their values before the write.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    // Default interval lengths in system clock cycles
    localparam int unsigned START_SU_STD = 20;
    localparam int unsigned START_HD_STD = 20;
    localparam int unsigned START_SU_FST = 10;
    localparam int unsigned START_HD_FST = 10;
    localparam int unsigned STOP_SU_STD  = 20;
    localparam int unsigned STOP_HD_STD  = 18;
    localparam int unsigned STOP_SU_FST  = 12;
    localparam int unsigned STOP_HD_FST  = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_SU,
        ST_START_HD,
        ST_STOP_SU,
        ST_STOP_HD
    } seq_state_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_START,
        REQ_STOP
    } req_kind_t;

    typedef struct packed {
        logic master;
        logic transmit;
        logic busy_bit;
    } wr_bits_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cond_req_decode.sv
module cond_req_decode
    import i2c_cond_pkg::*;
(
    input  logic      wr_stb,
    input  wr_bits_t  bits,
    input  logic      enable,
    input  logic      bus_busy,
    input  logic      idle,
    output req_kind_t req
);
    always_comb begin
        req = REQ_NONE;
        if (wr_stb && enable && idle && bits.master && bits.transmit) begin
            if (bits.busy_bit && !bus_busy)
                req = REQ_START;
            else if (!bits.busy_bit)
                req = REQ_STOP;
        end
    end
endmodule

// File: rtl/cond_interval_timer.sv
module cond_interval_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == target - 1'b1);

    // R11
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < target));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int unsigned P_START_SU_STD = START_SU_STD,
    parameter int unsigned P_START_HD_STD = START_HD_STD,
    parameter int unsigned P_START_SU_FST = START_SU_FST,
    parameter int unsigned P_START_HD_FST = START_HD_FST,
    parameter int unsigned P_STOP_SU_STD  = STOP_SU_STD,
    parameter int unsigned P_STOP_HD_STD  = STOP_HD_STD,
    parameter int unsigned P_STOP_SU_FST  = STOP_SU_FST,
    parameter int unsigned P_STOP_HD_FST  = STOP_HD_FST
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic fast_mode_i,
    input  logic wr_stb_i,
    input  logic wr_master_i,
    input  logic wr_transmit_i,
    input  logic wr_busy_i,
    output logic scl_o,
    output logic sda_o,
    output logic bus_busy_o,
    output logic byte_start_o
);
    localparam int unsigned MAX_IV = max4(
        max4(P_START_SU_STD, P_START_HD_STD, P_START_SU_FST, P_START_HD_FST),
        max4(P_STOP_SU_STD, P_STOP_HD_STD, P_STOP_SU_FST, P_STOP_HD_FST), 1, 1);
    localparam int unsigned CNT_W = $clog2(MAX_IV + 1);

    seq_state_t       state;
    req_kind_t        req;
    wr_bits_t         bits;
    logic             mode_q;
    logic             expired;
    logic [CNT_W-1:0] target;

    assign bits = '{master: wr_master_i, transmit: wr_transmit_i, busy_bit: wr_busy_i};

    cond_req_decode u_decode (
        .wr_stb   (wr_stb_i),
        .bits     (bits),
        .enable   (enable_i),
        .bus_busy (bus_busy_o),
        .idle     (state == ST_IDLE),
        .req      (req)
    );

    always_comb begin
        case (state)
            ST_START_SU: target = CNT_W'(mode_q ? P_START_SU_FST : P_START_SU_STD);
            ST_START_HD: target = CNT_W'(mode_q ? P_START_HD_FST : P_START_HD_STD);
            ST_STOP_SU:  target = CNT_W'(mode_q ? P_STOP_SU_FST  : P_STOP_SU_STD);
            ST_STOP_HD:  target = CNT_W'(mode_q ? P_STOP_HD_FST  : P_STOP_HD_STD);
            default:     target = CNT_W'(1);
        endcase
    end

    cond_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart ((req != REQ_NONE) || expired),
        .run     (state != ST_IDLE),
        .target  (target),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            scl_o        <= 1'b1;
            sda_o        <= 1'b1;
            bus_busy_o   <= 1'b0;
            byte_start_o <= 1'b0;
            mode_q       <= 1'b0;
        end else begin
            byte_start_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req == REQ_START) begin
                        state  <= ST_START_SU;
                        scl_o  <= 1'b1;
                        sda_o  <= 1'b1;
                        mode_q <= fast_mode_i;
                    end else if (req == REQ_STOP) begin
                        state  <= ST_STOP_SU;
                        scl_o  <= 1'b1;
                        sda_o  <= 1'b0;
                        mode_q <= fast_mode_i;
                    end
                end
                ST_START_SU: if (expired) begin
                    sda_o      <= 1'b0;
                    bus_busy_o <= 1'b1;
                    state      <= ST_START_HD;
                end
                ST_START_HD: if (expired) begin
                    scl_o        <= 1'b0;
                    byte_start_o <= 1'b1;
                    state        <= ST_IDLE;
                end
                ST_STOP_SU: if (expired) begin
                    sda_o <= 1'b1;
                    state <= ST_STOP_HD;
                end
                ST_STOP_HD: if (expired) begin
                    bus_busy_o <= 1'b0;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12
    sda_under_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_o != $past(sda_o)) |-> (scl_o && $past(scl_o)));

    // R5
    busy_with_sda_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy_o) |-> $fell(sda_o));

    // R6
    byte_pulse_on_scl_fall_chk: assert property (@(posedge clk) disable iff (rst)
        byte_start_o |-> ($fell(scl_o) && !$past(byte_start_o)));

    // R8
    busy_clear_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy_o) |-> (scl_o && sda_o));

    // R10
    disabled_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !enable_i) |=> ($stable(scl_o) && $stable(sda_o) && $stable(bus_busy_o)));
endmodule

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 3;
    // {fast, start setup, start hold, stop setup, stop hold}
    localparam int VEC [NVEC][5] = '{
        '{0, 20, 20, 20, 18},
        '{1, 10, 10, 12, 10},
        '{0, 20, 20, 20, 18}
    };

    logic clk = 0, rst = 1;
    logic enable_i = 1, fast_mode_i = 0;
    logic wr_stb_i = 0, wr_master_i = 0, wr_transmit_i = 0, wr_busy_i = 0;
    logic scl_o, sda_o, bus_busy_o, byte_start_o;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cond_gen i_i2c_cond_gen (
        .clk(clk), .rst(rst), .enable_i(enable_i), .fast_mode_i(fast_mode_i),
        .wr_stb_i(wr_stb_i), .wr_master_i(wr_master_i), .wr_transmit_i(wr_transmit_i),
        .wr_busy_i(wr_busy_i), .scl_o(scl_o), .sda_o(sda_o),
        .bus_busy_o(bus_busy_o), .byte_start_o(byte_start_o)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int lines();
        return {29'd0, scl_o, sda_o, bus_busy_o};
    endfunction

    task automatic do_write(input logic m, input logic t, input logic b);
        @(negedge clk);
        wr_master_i = m; wr_transmit_i = t; wr_busy_i = b; wr_stb_i = 1;
        @(negedge clk);
        wr_stb_i = 0;
    endtask

    task automatic wait_idle_check(input string rq, input int exp_lines);
        repeat (30) @(negedge clk);
        check(rq, lines(), exp_lines);
    endtask

    task automatic run_start(input int su, input int hd, input string rq, input bit inject);
        int n = 0, t_sda = -1, t_scl = -1, busy_at = 0, sb_at = 0;
        do_write(1, 1, 1);
        check("R2", {30'd0, scl_o, sda_o}, 3);
        while (n < 200 && t_scl < 0) begin
            @(negedge clk); n++;
            if (inject && n == 5) begin
                wr_master_i = 1; wr_transmit_i = 1; wr_busy_i = 0; wr_stb_i = 1;
            end
            if (inject && n == 6) wr_stb_i = 0;
            if (t_sda < 0 && sda_o == 0) begin t_sda = n; busy_at = bus_busy_o; end
            if (t_scl < 0 && scl_o == 0) begin t_scl = n; sb_at = byte_start_o; end
        end
        check(rq, t_sda, su);
        check(rq, t_scl, su + hd);
        check("R5", busy_at, 1);
        check("R6", sb_at, 1);
        @(negedge clk);
        check("R6", byte_start_o, 0);
    endtask

    task automatic run_stop(input int su, input int hd, input string rq);
        int n = 0, t_sda = -1, t_free = -1;
        do_write(1, 1, 0);
        check("R7", {30'd0, scl_o, sda_o}, 2);
        while (n < 200 && t_free < 0) begin
            @(negedge clk); n++;
            if (t_sda < 0 && sda_o == 1) t_sda = n;
            if (t_free < 0 && bus_busy_o == 0) t_free = n;
        end
        check(rq, t_sda, su);
        check(rq, t_free, su + hd);
        check("R12", {30'd0, scl_o, sda_o}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, scl_o, sda_o, bus_busy_o, byte_start_o}, 4'b1100);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            fast_mode_i = VEC[i][0][0];
            run_start(VEC[i][1], VEC[i][2], VEC[i][0] != 0 ? "R4" : "R3", 0);
            run_stop(VEC[i][3], VEC[i][4], VEC[i][0] != 0 ? "R9" : "R8");
        end

        fast_mode_i = 0;
        // R10 disabled START ignored
        enable_i = 0;
        do_write(1, 1, 1);
        wait_idle_check("R10", 3'b110);
        enable_i = 1;
        // R2 wrong bit patterns start nothing
        do_write(0, 1, 1);
        wait_idle_check("R2", 3'b110);
        do_write(1, 0, 1);
        wait_idle_check("R2", 3'b110);
        // bus held, then START while busy ignored
        run_start(20, 20, "R3", 0);
        do_write(1, 1, 1);
        wait_idle_check("R10", 3'b001);
        // R10 disabled STOP ignored
        enable_i = 0;
        do_write(1, 1, 0);
        wait_idle_check("R10", 3'b001);
        enable_i = 1;
        // R7 STOP needs transmit bit
        do_write(1, 0, 0);
        wait_idle_check("R7", 3'b001);
        run_stop(20, 18, "R8");
        // R11 write during active START is dropped
        run_start(20, 20, "R11", 1);
        run_stop(20, 18, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule